// File: doc/BRIEF.md
# Sub-slot 16 kbit/s Channel Switch

This block carries a 2-bit sub-channel, worth 16 kbit/s at one transfer per 8 kHz frame, between a line-side serial interface and a PCM highway. The sub-channel runs in both directions. On the line side it always sits in bits 7..6 of the even time slot of a slot pair. On the PCM side it can sit in any of the four bit pairs of an 8-bit PCM time slot.

A control memory holds one downstream entry and one upstream entry for each slot pair. Each entry has a 4-bit switching code and a pointer to a PCM time slot. Writes go through a simple register port into a shadow copy. That copy becomes active only at a frame boundary, so a frame is never switched under a mixed configuration.

Every bit pair collected during one frame is delivered in the next frame, in both directions. Because of this, the order in which PCM slots and line slots arrive within a frame has no effect on the result.

Top module: `ssw_switch`

## Requirements
- R1: A downstream code of 0111, 0110, 0101 or 0100 takes PCM bits 7..6, 5..4, 3..2 or 1..0 respectively from the PCM slot named by the pair's pointer. It places them on line bits 7..6 of that pair's even slot in the following frame.
- R2: An upstream code of 0111, 0110, 0101 or 0100 writes line bits 7..6, received in the previous frame on the pair's even slot, into PCM bits 7..6, 5..4, 3..2 or 1..0 of the pointed PCM slot. All other PCM bits pass through unchanged.
- R3: Downstream code 1011 deasserts the D-bit output enable (if_d_oe = 0) and drives the D bits as 11.
- R4: Any downstream code outside 01xx and 1011 drives the D bits as 11 with the output enable asserted.
- R5: Line bits 5..0 of an outgoing slot equal the if_tx_in value that accompanied it.
- R6: A PCM slot that no upstream entry with a 01xx code points to leaves the block unchanged.
- R7: A control memory write takes effect only at the next frame_start. Until the first frame_start after reset, every entry behaves as code 0000.
- R8: When several pairs switch upstream into the same PCM bit pair, the pair with the lowest index wins.
- R9: Each output strobe follows its input strobe by exactly one clock. After reset both output strobes are low and if_d_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| cfg_we | input | 1 | Control memory write strobe |
| cfg_pair | input | PAIR_W | Slot pair being written |
| cfg_dir | input | 1 | 0 selects the downstream entry, 1 the upstream entry |
| cfg_code | input | 4 | Switching code |
| cfg_ptr | input | PTR_W | PCM time slot pointer |
| pcm_vld | input | 1 | A PCM slot is presented |
| pcm_ts | input | PTR_W | Index of the presented PCM slot |
| pcm_rx | input | 8 | Downstream byte received from the PCM highway |
| pcm_tx_in | input | 8 | Upstream byte before insertion |
| pcm_tx_out | output | 8 | Upstream byte after insertion |
| pcm_tx_vld | output | 1 | pcm_tx_out is valid |
| if_vld | input | 1 | A line-side even slot is presented |
| if_slot | input | PAIR_W | Slot pair index of that slot |
| if_rx_d | input | 2 | Received D bits (line bits 7..6) |
| if_tx_in | input | 6 | Outgoing line bits 5..0 |
| if_tx_out | output | 8 | Outgoing line slot byte |
| if_d_oe | output | 1 | Output enable for line bits 7..6 |
| if_tx_vld | output | 1 | if_tx_out and if_d_oe are valid |

## Verification
The assertions assume a few things about the inputs. No slot strobe is raised in a frame_start cycle. Both strobes are low while reset is held. pcm_ts and if_slot stay below their configured counts.

The bench follows all of these rules. It presents slots only in the cycles between boundary pulses and holds every strobe low during reset. It walks indices only over 0..NUM_PCM_TS-1 and 0..NUM_PAIRS-1.

The bench sweeps every downstream and upstream code class across every pointer and pair. It also creates frames in which two pairs collide on one PCM bit pair. One control write is placed in the middle of a frame.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

   localparam int SLOT_W = 8;
   localparam int CODE_W = 4;

   typedef logic [1:0] dpair_t;

   localparam logic [CODE_W-1:0] CODE_HIZ  = 4'b1011;
   localparam logic [CODE_W-1:0] CODE_IDLE = 4'b0000;

   // Codes 01xx switch; the low two bits select the PCM bit pair.
   function automatic logic is_switch(input logic [CODE_W-1:0] c);
      return c[3:2] == 2'b01;
   endfunction

   function automatic dpair_t pick_pair(input logic [SLOT_W-1:0] b, input logic [1:0] sel);
      dpair_t r;
      case (sel)
         2'b11:   r = b[7:6];
         2'b10:   r = b[5:4];
         2'b01:   r = b[3:2];
         default: r = b[1:0];
      endcase
      return r;
   endfunction

   function automatic logic [SLOT_W-1:0] put_pair(input logic [SLOT_W-1:0] b,
                                                  input logic [1:0] sel,
                                                  input dpair_t d);
      logic [SLOT_W-1:0] r;
      r = b;
      case (sel)
         2'b11:   r[7:6] = d;
         2'b10:   r[5:4] = d;
         2'b01:   r[3:2] = d;
         default: r[1:0] = d;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ssw_ctrl_mem.sv
module ssw_ctrl_mem
   import ssw_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int PTR_W     = 3,
   parameter int PAIR_W    = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               frame_start,
   input  logic                               cfg_we,
   input  logic [PAIR_W-1:0]                  cfg_pair,
   input  logic                               cfg_dir,
   input  logic [CODE_W-1:0]                  cfg_code,
   input  logic [PTR_W-1:0]                   cfg_ptr,
   output logic [NUM_PAIRS-1:0][CODE_W-1:0]   ds_code,
   output logic [NUM_PAIRS-1:0][PTR_W-1:0]    ds_ptr,
   output logic [NUM_PAIRS-1:0][CODE_W-1:0]   us_code,
   output logic [NUM_PAIRS-1:0][PTR_W-1:0]    us_ptr
);

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_entry
      logic [CODE_W-1:0] sh_ds_code, sh_us_code, ac_ds_code, ac_us_code;
      logic [PTR_W-1:0]  sh_ds_ptr,  sh_us_ptr,  ac_ds_ptr,  ac_us_ptr;
      logic              hit;

      assign hit = cfg_we && (cfg_pair == PAIR_W'(p));

      // Shadow copy: written at any time by the register port.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_ds_code <= CODE_IDLE;
            sh_us_code <= CODE_IDLE;
            sh_ds_ptr  <= '0;
            sh_us_ptr  <= '0;
         end else if (hit) begin
            if (!cfg_dir) begin
               sh_ds_code <= cfg_code;
               sh_ds_ptr  <= cfg_ptr;
            end else begin
               sh_us_code <= cfg_code;
               sh_us_ptr  <= cfg_ptr;
            end
         end
      end

      // Active copy: loaded only on the frame boundary.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ac_ds_code <= CODE_IDLE;
            ac_us_code <= CODE_IDLE;
            ac_ds_ptr  <= '0;
            ac_us_ptr  <= '0;
         end else if (frame_start) begin
            ac_ds_code <= sh_ds_code;
            ac_us_code <= sh_us_code;
            ac_ds_ptr  <= sh_ds_ptr;
            ac_us_ptr  <= sh_us_ptr;
         end
      end

      assign ds_code[p] = ac_ds_code;
      assign ds_ptr[p]  = ac_ds_ptr;
      assign us_code[p] = ac_us_code;
      assign us_ptr[p]  = ac_us_ptr;
   end

endmodule

// File: rtl/ssw_ds_path.sv
module ssw_ds_path
   import ssw_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int PTR_W     = 3,
   parameter int PAIR_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              frame_start,
   input  logic                              pcm_vld,
   input  logic [PTR_W-1:0]                  pcm_ts,
   input  logic [SLOT_W-1:0]                 pcm_rx,
   input  logic                              if_vld,
   input  logic [PAIR_W-1:0]                 if_slot,
   input  logic [SLOT_W-3:0]                 if_tx_in,
   input  logic [NUM_PAIRS-1:0][CODE_W-1:0]  ds_code,
   input  logic [NUM_PAIRS-1:0][PTR_W-1:0]   ds_ptr,
   output logic [SLOT_W-1:0]                 if_tx_out,
   output logic                              if_d_oe,
   output logic                              if_tx_vld
);

   logic [NUM_PAIRS-1:0][1:0] hold_vec;

   // Per pair: collect during a frame, present during the next one.
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      dpair_t cap_q, hold_q;
      logic   take;

      assign take = pcm_vld && is_switch(ds_code[p]) && (ds_ptr[p] == pcm_ts);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_q  <= 2'b11;
            hold_q <= 2'b11;
         end else if (frame_start) begin
            hold_q <= cap_q;
            cap_q  <= 2'b11;
         end else if (take) begin
            cap_q  <= pick_pair(pcm_rx, ds_code[p][1:0]);
         end
      end

      assign hold_vec[p] = hold_q;
   end

   logic [CODE_W-1:0] cur_code;
   dpair_t            d_next;

   always_comb begin
      cur_code = ds_code[if_slot];
      d_next   = is_switch(cur_code) ? hold_vec[if_slot] : 2'b11;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if_tx_vld <= 1'b0;
         if_tx_out <= '1;
         if_d_oe   <= 1'b1;
      end else begin
         if_tx_vld <= if_vld;
         if (if_vld) begin
            if_tx_out <= {d_next, if_tx_in};
            if_d_oe   <= (cur_code != CODE_HIZ);
         end
      end
   end

endmodule

// File: rtl/ssw_us_path.sv
module ssw_us_path
   import ssw_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int PTR_W     = 3,
   parameter int PAIR_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              frame_start,
   input  logic                              if_vld,
   input  logic [PAIR_W-1:0]                 if_slot,
   input  logic [1:0]                        if_rx_d,
   input  logic                              pcm_vld,
   input  logic [PTR_W-1:0]                  pcm_ts,
   input  logic [SLOT_W-1:0]                 pcm_tx_in,
   input  logic [NUM_PAIRS-1:0][CODE_W-1:0]  us_code,
   input  logic [NUM_PAIRS-1:0][PTR_W-1:0]   us_ptr,
   output logic [SLOT_W-1:0]                 pcm_tx_out,
   output logic                              pcm_tx_vld
);

   logic [NUM_PAIRS-1:0][1:0] hold_vec;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      dpair_t cap_q, hold_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cap_q  <= 2'b11;
            hold_q <= 2'b11;
         end else if (frame_start) begin
            hold_q <= cap_q;
            cap_q  <= 2'b11;
         end else if (if_vld && (if_slot == PAIR_W'(p))) begin
            cap_q  <= if_rx_d;
         end
      end

      assign hold_vec[p] = hold_q;
   end

   // Highest index first, so the lowest matching pair is written last.
   logic [SLOT_W-1:0] merged;

   always_comb begin
      merged = pcm_tx_in;
      for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
         if (is_switch(us_code[p]) && (us_ptr[p] == pcm_ts))
            merged = put_pair(merged, us_code[p][1:0], hold_vec[p]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcm_tx_vld <= 1'b0;
         pcm_tx_out <= '1;
      end else begin
         pcm_tx_vld <= pcm_vld;
         if (pcm_vld) pcm_tx_out <= merged;
      end
   end

endmodule

// File: rtl/ssw_switch.sv
module ssw_switch
   import ssw_pkg::*;
#(
   parameter int NUM_PAIRS  = 4,
   parameter int NUM_PCM_TS = 8,
   localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
   localparam int PTR_W  = (NUM_PCM_TS > 1) ? $clog2(NUM_PCM_TS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              cfg_we,
   input  logic [PAIR_W-1:0] cfg_pair,
   input  logic              cfg_dir,
   input  logic [3:0]        cfg_code,
   input  logic [PTR_W-1:0]  cfg_ptr,
   input  logic              pcm_vld,
   input  logic [PTR_W-1:0]  pcm_ts,
   input  logic [7:0]        pcm_rx,
   input  logic [7:0]        pcm_tx_in,
   output logic [7:0]        pcm_tx_out,
   output logic              pcm_tx_vld,
   input  logic              if_vld,
   input  logic [PAIR_W-1:0] if_slot,
   input  logic [1:0]        if_rx_d,
   input  logic [5:0]        if_tx_in,
   output logic [7:0]        if_tx_out,
   output logic              if_d_oe,
   output logic              if_tx_vld
);

   if (NUM_PAIRS < 1 || NUM_PAIRS > 64) begin : g_bad_pairs
      $fatal(1, "NUM_PAIRS out of range");
   end
   if (NUM_PCM_TS < 2 || NUM_PCM_TS > 1024) begin : g_bad_ts
      $fatal(1, "NUM_PCM_TS out of range");
   end

   logic [NUM_PAIRS-1:0][CODE_W-1:0] ds_code, us_code;
   logic [NUM_PAIRS-1:0][PTR_W-1:0]  ds_ptr, us_ptr;

   ssw_ctrl_mem #(.NUM_PAIRS(NUM_PAIRS), .PTR_W(PTR_W), .PAIR_W(PAIR_W)) u_cm (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .cfg_we     (cfg_we),
      .cfg_pair   (cfg_pair),
      .cfg_dir    (cfg_dir),
      .cfg_code   (cfg_code),
      .cfg_ptr    (cfg_ptr),
      .ds_code    (ds_code),
      .ds_ptr     (ds_ptr),
      .us_code    (us_code),
      .us_ptr     (us_ptr)
   );

   ssw_ds_path #(.NUM_PAIRS(NUM_PAIRS), .PTR_W(PTR_W), .PAIR_W(PAIR_W)) u_ds (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .pcm_vld    (pcm_vld),
      .pcm_ts     (pcm_ts),
      .pcm_rx     (pcm_rx),
      .if_vld     (if_vld),
      .if_slot    (if_slot),
      .if_tx_in   (if_tx_in),
      .ds_code    (ds_code),
      .ds_ptr     (ds_ptr),
      .if_tx_out  (if_tx_out),
      .if_d_oe    (if_d_oe),
      .if_tx_vld  (if_tx_vld)
   );

   ssw_us_path #(.NUM_PAIRS(NUM_PAIRS), .PTR_W(PTR_W), .PAIR_W(PAIR_W)) u_us (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .if_vld     (if_vld),
      .if_slot    (if_slot),
      .if_rx_d    (if_rx_d),
      .pcm_vld    (pcm_vld),
      .pcm_ts     (pcm_ts),
      .pcm_tx_in  (pcm_tx_in),
      .us_code    (us_code),
      .us_ptr     (us_ptr),
      .pcm_tx_out (pcm_tx_out),
      .pcm_tx_vld (pcm_tx_vld)
   );

endmodule

// File: rtl/ssw_checker.sv
module ssw_checker #(
   parameter int NUM_PAIRS  = 4,
   parameter int NUM_PCM_TS = 8,
   localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
   localparam int PTR_W  = (NUM_PCM_TS > 1) ? $clog2(NUM_PCM_TS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              pcm_vld,
   input logic [PTR_W-1:0]  pcm_ts,
   input logic [7:0]        pcm_tx_in,
   input logic [7:0]        pcm_tx_out,
   input logic              pcm_tx_vld,
   input logic              if_vld,
   input logic [PAIR_W-1:0] if_slot,
   input logic [5:0]        if_tx_in,
   input logic [7:0]        if_tx_out,
   input logic              if_d_oe,
   input logic              if_tx_vld
);

   logic seen_frame;

   always_ff @(posedge clk) begin
      if (!rst_n)           seen_frame <= 1'b0;
      else if (frame_start) seen_frame <= 1'b1;
   end

   // Input rule: slot strobes never coincide with a boundary pulse.
   assert_quiet_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (!pcm_vld && !if_vld));

   assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pcm_vld |-> (int'(pcm_ts) < NUM_PCM_TS)) and (if_vld |-> (int'(if_slot) < NUM_PAIRS)));

   assert_if_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      if_tx_vld == $past(if_vld));

   assert_pcm_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_tx_vld == $past(pcm_vld));

   assert_hiz_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (if_tx_vld && !if_d_oe) |-> (if_tx_out[7:6] == 2'b11));

   assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      if_tx_vld |-> (if_tx_out[5:0] == $past(if_tx_in)));

   assert_idle_pcm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_frame && pcm_tx_vld) |-> (pcm_tx_out == $past(pcm_tx_in)));

   assert_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_frame && if_tx_vld) |-> (if_d_oe && (if_tx_out[7:6] == 2'b11)));

endmodule

bind ssw_switch ssw_checker #(.NUM_PAIRS(NUM_PAIRS), .NUM_PCM_TS(NUM_PCM_TS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_start(frame_start),
   .pcm_vld    (pcm_vld),
   .pcm_ts     (pcm_ts),
   .pcm_tx_in  (pcm_tx_in),
   .pcm_tx_out (pcm_tx_out),
   .pcm_tx_vld (pcm_tx_vld),
   .if_vld     (if_vld),
   .if_slot    (if_slot),
   .if_tx_in   (if_tx_in),
   .if_tx_out  (if_tx_out),
   .if_d_oe    (if_d_oe),
   .if_tx_vld  (if_tx_vld)
);

// File: tb/tb_ssw_switch.sv
`timescale 1ns/1ps
module tb_ssw_switch;

   localparam int NP  = 4;
   localparam int NTS = 8;
   localparam int PW  = 2;
   localparam int TW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic cfg_we = 1'b0;
   logic [PW-1:0] cfg_pair = '0;
   logic cfg_dir = 1'b0;
   logic [3:0] cfg_code = '0;
   logic [TW-1:0] cfg_ptr = '0;
   logic pcm_vld = 1'b0;
   logic [TW-1:0] pcm_ts = '0;
   logic [7:0] pcm_rx = '0, pcm_tx_in = '0, pcm_tx_out;
   logic pcm_tx_vld;
   logic if_vld = 1'b0;
   logic [PW-1:0] if_slot = '0;
   logic [1:0] if_rx_d = '0;
   logic [5:0] if_tx_in = '0;
   logic [7:0] if_tx_out;
   logic if_d_oe, if_tx_vld;

   always #5 clk = ~clk;

   ssw_switch #(.NUM_PAIRS(NP), .NUM_PCM_TS(NTS)) dut (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Specification model state
   int sh_dc[NP], sh_dp[NP], sh_uc[NP], sh_up[NP];
   int ac_dc[NP], ac_dp[NP], ac_uc[NP], ac_up[NP];
   int dcap[NP], dhold[NP], ucap[NP], uhold[NP];

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit sw(int c); return (c >> 2) == 1; endfunction
   function automatic int pick(int b, int s); return (b >> (2*s)) & 3; endfunction
   function automatic int put(int b, int s, int d);
      return (b & ~(3 << (2*s)) & 255) | (d << (2*s));
   endfunction

   task automatic cfg_write(int p, int dir, int code, int ptr);
      cfg_we = 1'b1; cfg_pair = PW'(p); cfg_dir = dir[0];
      cfg_code = code[3:0]; cfg_ptr = TW'(ptr);
      @(negedge clk);
      cfg_we = 1'b0;
      if (dir == 0) begin sh_dc[p] = code; sh_dp[p] = ptr; end
      else          begin sh_uc[p] = code; sh_up[p] = ptr; end
   endtask

   task automatic boundary();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      for (int p = 0; p < NP; p++) begin
         ac_dc[p] = sh_dc[p]; ac_dp[p] = sh_dp[p];
         ac_uc[p] = sh_uc[p]; ac_up[p] = sh_up[p];
         dhold[p] = dcap[p];  dcap[p] = 3;
         uhold[p] = ucap[p];  ucap[p] = 3;
      end
   endtask

   task automatic pcm_slot(int ts, int rx, int txin);
      int v = txin, n = 0;
      for (int p = NP - 1; p >= 0; p--)
         if (sw(ac_uc[p]) && ac_up[p] == ts) begin
            v = put(v, ac_uc[p] & 3, uhold[p]);
            n++;
         end
      pcm_vld = 1'b1; pcm_ts = TW'(ts); pcm_rx = rx[7:0]; pcm_tx_in = txin[7:0];
      @(negedge clk);
      pcm_vld = 1'b0;
      check("R9 pcm strobe", int'(pcm_tx_vld), 1);
      if (n == 0)      check("R6 pcm passthrough", int'(pcm_tx_out), v);
      else if (n == 1) check("R2 pcm insert", int'(pcm_tx_out), v);
      else             check("R8 pcm priority", int'(pcm_tx_out), v);
      for (int p = 0; p < NP; p++)
         if (sw(ac_dc[p]) && ac_dp[p] == ts) dcap[p] = pick(rx, ac_dc[p] & 3);
   endtask

   task automatic if_slot_drive(int p, int rx, int txin, string dtag);
      int c = ac_dc[p];
      int d = sw(c) ? dhold[p] : 3;
      string tag;
      if (dtag.len() != 0) tag = dtag;
      else if (sw(c))      tag = "R1 line D bits";
      else if (c == 11)    tag = "R3 line D bits";
      else                 tag = "R4 line D bits";
      if_vld = 1'b1; if_slot = PW'(p); if_rx_d = rx[1:0]; if_tx_in = txin[5:0];
      @(negedge clk);
      if_vld = 1'b0;
      check("R9 line strobe", int'(if_tx_vld), 1);
      check(tag, int'(if_tx_out[7:6]), d);
      check("R3 line oe", int'(if_d_oe), (c == 11) ? 0 : 1);
      check("R5 line low bits", int'(if_tx_out[5:0]), txin);
      ucap[p] = rx;
   endtask

   function automatic int ds_code_of(int k);
      case (k)
         0, 1, 2, 3: return 4 + k;
         4: return 11;
         5: return 10;
         6: return 0;
         default: return 15;
      endcase
   endfunction

   function automatic int us_code_of(int k);
      if (k < 4) return 4 + k;
      return (k == 4) ? 0 : 8;
   endfunction

   initial begin
      for (int p = 0; p < NP; p++) begin
         sh_dc[p] = 0; sh_dp[p] = 0; sh_uc[p] = 0; sh_up[p] = 0;
         ac_dc[p] = 0; ac_dp[p] = 0; ac_uc[p] = 0; ac_up[p] = 0;
         dcap[p] = 3; dhold[p] = 3; ucap[p] = 3; uhold[p] = 3;
      end
      repeat (5) @(negedge clk);
      check("R9 reset pcm strobe", int'(pcm_tx_vld), 0);
      check("R9 reset line strobe", int'(if_tx_vld), 0);
      check("R9 reset oe", int'(if_d_oe), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: writes before the first boundary must not act yet
      for (int p = 0; p < NP; p++) begin
         cfg_write(p, 0, 11, p);
         cfg_write(p, 1, 7, p);
      end
      for (int t = 0; t < NTS; t++) pcm_slot(t, t * 29 + 3, 255 - t * 7);
      for (int p = 0; p < NP; p++) if_slot_drive(p, p, p * 9, "R7 pre-boundary D bits");

      for (int f = 0; f < 24; f++) begin
         for (int p = 0; p < NP; p++) begin
            int uc = us_code_of((f + 2 * p) % 6);
            int up = (f + p) % NTS;
            if (f % 4 == 3 && p == 1) begin
               uc = sh_uc[0]; up = sh_up[0];
               if (!sw(uc)) uc = 6;
               cfg_write(0, 1, uc, up);
            end
            cfg_write(p, 0, ds_code_of((f + p) % 8), (f * 3 + p) % NTS);
            cfg_write(p, 1, uc, up);
         end
         boundary();
         for (int t = 0; t < NTS; t++)
            pcm_slot(t, (t * 37 + f * 91 + 13) & 255, (t * 53 + f * 17 + 200) & 255);
         if (f == 10) begin
            int old = ac_dc[0];
            cfg_write(0, 0, 11, 0);
            if_slot_drive(0, (f + 1) % 4, 5, "R7 mid-frame write");
            check("R7 oe unchanged mid-frame", int'(if_d_oe), (old == 11) ? 0 : 1);
            for (int p = 1; p < NP; p++) if_slot_drive(p, (p + f) % 4, (p * 23 + f * 7) & 63, "");
         end else begin
            for (int p = 0; p < NP; p++) if_slot_drive(p, (p + f) % 4, (p * 23 + f * 7) & 63, "");
         end
         @(negedge clk);
         check("R9 strobes drop", int'(pcm_tx_vld) + int'(if_tx_vld), 0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule